// File: doc/BRIEF.md
# Brightness Source Selector With Duty Measurement

This block produces a 16-bit brightness request for a backlight pipeline. The request can come from two places. One is a PWM brightness signal from a host, whose duty cycle the block measures against its own system clock. The other is a 16-bit register that the host writes. A 2-bit mode input picks the measured duty, the register, or the scaled product of the two. The product lets a PWM input dim a level that the register sets.

The duty meter counts high cycles and period cycles between successive rising edges of the synchronised input. It scales their ratio to a full 16-bit range. A longer input period therefore gives a finer result. A hysteresis code sets how far a new measurement must move before it replaces the held value, so small jitter does not reach the output. When no rising edge arrives for a set number of clocks, the held duty goes to all-zeros or all-ones, following the input level.

Top module: `bright_src_sel`

## Requirements
- R1: During and right after reset, `bright_out`, the brightness register and the held duty are all 0x0000.
- R2: Each rising edge of the synchronised `pwm_in` that follows an earlier valid rising edge yields a measurement floor(H*65535/P). P is the number of clocks from the previous rising edge to this one, and H is the number of those clocks in which the input was high.
- R3: `hyst_sel` sets the minimum step: code 0 = 0, code 1 = 1, code 2 = 4, code 3 = 16 LSBs. A measurement replaces the held duty only when its absolute difference from the held duty is at least that step. Otherwise the held duty is unchanged.
- R4: If no rising edge is seen for `TIMEOUT_CYC` clocks, the held duty becomes 0xFFFF while the input is high and 0x0000 while it is low. This bypasses hysteresis. The next rising edge only re-arms the meter, and the edge after it gives the next measurement.
- R5: When `reg_wr` is high at a clock edge, the register loads `reg_wdata`. In register mode the new value reaches `bright_out` at the second clock edge after the write.
- R6: `mode_sel` code 0 routes the held duty to `bright_out`. Codes 1 and 3 route the register.
- R7: `mode_sel` code 2 routes (duty*register)>>16. When both operands are 0xFFFF, the output is 0xFFFF instead of 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | 1 | Asynchronous PWM brightness input |
| hyst_sel | input | 2 | Hysteresis step code |
| mode_sel | input | 2 | Brightness source code |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| bright_out | output | 16 | Registered brightness request |

## Verification
On every cycle, assertions check four things:
- the held duty moves only on a rising edge or a timeout, and every step it takes on a rising edge is at least the selected hysteresis;
- a timeout with the input high forces all-ones;
- a register write lands in the register, and the duty and saturating-product paths reach the output one cycle later.

Only the bench scenarios can show the rest:
- the measured values are numerically correct for particular high/period pairs;
- a sub-threshold change is rejected while a larger one passes, across a sequence of hysteresis settings;
- the low-level timeout result and the two-edge write-to-output latency are as specified.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    typedef enum logic [1:0] {
        SRC_DUTY    = 2'd0,
        SRC_REG     = 2'd1,
        SRC_PROD    = 2'd2,
        SRC_REG_ALT = 2'd3
    } src_mode_e;

    // Minimum accepted step in LSBs for each hysteresis code
    function automatic logic [15:0] hyst_step(input logic [1:0] code);
        case (code)
            2'd0:    hyst_step = 16'd0;
            2'd1:    hyst_step = 16'd1;
            2'd2:    hyst_step = 16'd4;
            default: hyst_step = 16'd16;
        endcase
    endfunction

    function automatic logic [15:0] abs_gap(input logic [15:0] a, input logic [15:0] b);
        abs_gap = (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/bsel_sync.sv
module bsel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/bsel_duty_meter.sv
module bsel_duty_meter
    import bsel_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096,
    parameter int OUT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_in,
    input  logic [1:0]       hyst_sel,
    output logic [OUT_W-1:0] duty_held
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam int QW = CW + OUT_W;
    localparam logic [CW-1:0]    CNT_LIM  = CW'(TIMEOUT_CYC);
    localparam logic [OUT_W-1:0] FULL_VAL = {OUT_W{1'b1}};

    typedef struct packed {
        logic             lvl_prev;
        logic             armed;
        logic [CW-1:0]    per_cnt;
        logic [CW-1:0]    hi_cnt;
        logic [OUT_W-1:0] held;
    } meter_st_t;

    meter_st_t st_d, st_q;

    logic             rise, tmo, pass;
    logic [QW-1:0]    numer, denom, quot;
    logic [OUT_W-1:0] meas, gap;

    always_comb begin
        rise  = lvl_in & ~st_q.lvl_prev;
        tmo   = (st_q.per_cnt == CNT_LIM);
        numer = {st_q.hi_cnt, {OUT_W{1'b0}}} - {{OUT_W{1'b0}}, st_q.hi_cnt};
        denom = {{OUT_W{1'b0}}, (st_q.per_cnt == '0) ? CW'(1) : st_q.per_cnt};
        quot  = numer / denom;
        meas  = (quot > QW'(FULL_VAL)) ? FULL_VAL : quot[OUT_W-1:0];
        gap   = abs_gap(meas, st_q.held);
        pass  = (gap >= hyst_step(hyst_sel));

        st_d = st_q;
        st_d.lvl_prev = lvl_in;
        if (rise) begin
            st_d.per_cnt = CW'(1);
            st_d.hi_cnt  = CW'(1);
            st_d.armed   = 1'b1;
            if (st_q.armed && pass) st_d.held = meas;
        end else if (tmo) begin
            st_d.armed = 1'b0;
            st_d.held  = lvl_in ? FULL_VAL : '0;
        end else begin
            st_d.per_cnt = st_q.per_cnt + 1'b1;
            if (lvl_in && st_q.hi_cnt != CNT_LIM) st_d.hi_cnt = st_q.hi_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_held = st_q.held;

    // R3
    hyst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.held) && !$past(tmo)) |->
            (abs_gap(st_q.held, $past(st_q.held)) >= hyst_step($past(hyst_sel))));

    // R2
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && !tmo) |=> $stable(st_q.held));

    // R4
    tmo_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !rise && lvl_in) |=> (duty_held == FULL_VAL));
endmodule

// File: rtl/bsel_src_mux.sv
module bsel_src_mux
    import bsel_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [OUT_W-1:0] duty_val,
    input  logic [OUT_W-1:0] reg_val,
    output logic [OUT_W-1:0] bright
);
    localparam int PW = 2 * OUT_W;
    localparam logic [OUT_W-1:0] FULL_VAL = {OUT_W{1'b1}};
    localparam logic [PW-1:0]    FULL_SQ  = PW'(FULL_VAL) * PW'(FULL_VAL);

    typedef struct packed {
        logic [OUT_W-1:0] out;
    } mux_st_t;

    mux_st_t st_d, st_q;

    logic [PW-1:0]    prod_full;
    logic [OUT_W-1:0] prod_val;
    src_mode_e        mode;

    always_comb begin
        mode      = src_mode_e'(mode_sel);
        prod_full = PW'(duty_val) * PW'(reg_val);
        prod_val  = (prod_full == FULL_SQ) ? FULL_VAL : prod_full[PW-1:OUT_W];

        st_d = st_q;
        case (mode)
            SRC_DUTY: st_d.out = duty_val;
            SRC_PROD: st_d.out = prod_val;
            default:  st_d.out = reg_val;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bright = st_q.out;

    // R6
    duty_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0) |=> (bright == $past(duty_val)));

    // R7
    prod_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && duty_val == FULL_VAL && reg_val == FULL_VAL) |=> (bright == FULL_VAL));
endmodule

// File: rtl/bright_src_sel.sv
module bright_src_sel
    import bsel_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096,
    parameter int SYNC_STAGES = 2,
    parameter int BR_W        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwm_in,
    input  logic [1:0]      hyst_sel,
    input  logic [1:0]      mode_sel,
    input  logic            reg_wr,
    input  logic [BR_W-1:0] reg_wdata,
    output logic [BR_W-1:0] bright_out
);
    typedef struct packed {
        logic [BR_W-1:0] bright_reg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic            pwm_sync;
    logic [BR_W-1:0] duty_held;

    always_comb begin
        st_d = st_q;
        if (reg_wr) st_d.bright_reg = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    bsel_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwm_in),
        .sync_out (pwm_sync)
    );

    bsel_duty_meter #(.TIMEOUT_CYC(TIMEOUT_CYC), .OUT_W(BR_W)) meter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_in    (pwm_sync),
        .hyst_sel  (hyst_sel),
        .duty_held (duty_held)
    );

    bsel_src_mux #(.OUT_W(BR_W)) mux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .duty_val (duty_held),
        .reg_val  (st_q.bright_reg),
        .bright   (bright_out)
    );

    // R5
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (st_q.bright_reg == $past(reg_wdata)));
endmodule

// File: tb/bright_src_sel_tb_top.sv
module bright_src_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_in = 1'b0;
    logic [1:0]  hyst_sel = 2'd0;
    logic [1:0]  mode_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] bright_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // PWM generator: new high/period settings take effect only at a period boundary
    int  gen_h = 0, gen_p = 0, cur_h = 0, cur_p = 0, ph = 0;
    logic gen_lvl = 1'b0;

    always #10 clk = ~clk;

    bright_src_sel dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .hyst_sel(hyst_sel),
        .mode_sel(mode_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .bright_out(bright_out)
    );

    always @(negedge clk) begin
        if (ph == 0) begin
            cur_h = gen_h;
            cur_p = gen_p;
        end
        if (cur_p == 0) begin
            pwm_in <= gen_lvl;
            ph = 0;
        end else begin
            pwm_in <= (ph < cur_h);
            ph = (ph + 1 >= cur_p) ? 0 : ph + 1;
        end
    end

    // fields: mode[65:64] reg[63:48] high[47:32] period[31:16] expected[15:0]
    localparam logic [65:0] VEC [0:7] = '{
        {2'd0, 16'h0000, 16'd25, 16'd100, 16'd16383},  // R2
        {2'd0, 16'h0000, 16'd30, 16'd40,  16'd49151},  // R2
        {2'd1, 16'h1234, 16'd25, 16'd100, 16'd4660},   // R6
        {2'd2, 16'h8000, 16'd50, 16'd100, 16'd16383},  // R7
        {2'd2, 16'hFFFF, 16'd30, 16'd40,  16'd49150},  // R7
        {2'd3, 16'h00FF, 16'd10, 16'd100, 16'd255},    // R6
        {2'd1, 16'h0000, 16'd10, 16'd100, 16'd0},      // R6
        {2'd0, 16'h4321, 16'd1,  16'd64,  16'd1023}    // R2
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: bright_out=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic write_reg(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic set_pwm(input int h, input int p);
        gen_h = h;
        gen_p = p;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        check("R1 in reset", bright_out, 16'h0000);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 after reset", bright_out, 16'h0000);

        // Table walk, hysteresis off
        for (int i = 0; i < 8; i++) begin
            logic [65:0] v;
            v = VEC[i];
            mode_sel = v[65:64];
            write_reg(v[63:48]);
            set_pwm(int'(v[47:32]), int'(v[31:16]));
            wait_cyc(6 * int'(v[31:16]) + 40);
            check($sformatf("R2/R6/R7 vector %0d", i), bright_out, v[15:0]);
        end

        // R5: register write reaches output on second edge
        mode_sel = 2'd1;
        wait_cyc(3);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = 16'hA5A5;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R5 one edge after write", bright_out, 16'h4321);
        @(negedge clk);
        check("R5 two edges after write", bright_out, 16'hA5A5);

        // R4: held high with no edges
        mode_sel = 2'd0;
        gen_lvl = 1'b1;
        set_pwm(0, 0);
        wait_cyc(4400);
        check("R4 timeout high", bright_out, 16'hFFFF);

        // R7: saturated product
        write_reg(16'hFFFF);
        mode_sel = 2'd2;
        wait_cyc(3);
        check("R7 product saturation", bright_out, 16'hFFFF);

        // R4: held low with no edges
        mode_sel = 2'd0;
        gen_lvl = 1'b0;
        wait_cyc(4400);
        check("R4 timeout low", bright_out, 16'h0000);

        // R3: hysteresis sequence
        hyst_sel = 2'd0;
        set_pwm(50, 100);
        wait_cyc(640);
        check("R3 base value", bright_out, 16'd32767);
        hyst_sel = 2'd3;
        set_pwm(2000, 3999);
        wait_cyc(3 * 3999 + 300);
        check("R3 step 8 below 16 ignored", bright_out, 16'd32767);
        hyst_sel = 2'd2;
        wait_cyc(2 * 3999 + 100);
        check("R3 step 8 passes 4", bright_out, 16'd32775);
        hyst_sel = 2'd3;
        set_pwm(50, 100);
        wait_cyc(4000 + 700);
        check("R3 step back ignored", bright_out, 16'd32775);
        set_pwm(60, 100);
        wait_cyc(700);
        check("R3 large step passes", bright_out, 16'd39321);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule